// File: doc/BRIEF.md
# Image Sensor Reset and Standby Sequencer

This block sits on the host side of an image sensor link and drives two control lines: the sensor's active-low hardware reset and its standby level. When power is good it holds reset low for a minimum time, then releases it. After a fixed number of sensor clocks it raises a flag that tells the serial-interface master it may begin talking to the sensor.

Standby requests from the host are not passed straight to the pin. A request only takes effect on a frame-valid edge. Once standby is applied, it is held for the minimum time that belongs to the edge that started it. Release is refused while the elapsed blanking time since the last frame-valid fall lies in the sensor's unsafe window. Transitions on the standby line are always a few clocks apart.

After standby is released, the block watches for frame activity to resume. If no frame starts within a programmable number of measured frame periods, the sensor is assumed to be stuck in standby. The block then raises an alarm and runs the whole reset sequence again. The frame period is measured continuously from frame-valid rising edges. The block's clock is the sensor clock, and the row-time strobe comes from the same domain.

Top module: `snsr_stby_ctrl`

## Requirements
- R1: After `pwr_good_i` rises, `sensor_rst_no` stays low for ceil(RST_NS/CLK_NS) clock cycles, then goes high. With the defaults (8 ns, 750 ns) it goes high after the 94th rising edge.
- R2: `iface_rdy_o` goes high on the 10th (IFACE_WAIT) rising edge after reset release. It is low whenever `sensor_rst_no` is low.
- R3: `sensor_stby_o` rises only in the cycle after `fv_i` is seen rising or falling while `stby_req_i` is high. A request raised at any other time is held pending until the next such edge.
- R4: If standby began on a frame-valid rising edge, it is held for at least the measured frame period. This period is the number of clocks between two successive `fv_i` rising edges, and defaults to DFLT_FRAME until one is measured.
- R5: If standby began on a frame-valid falling edge, it is held for at least `vblank_i` + 5 row strobes.
- R6: Standby is never released while the number of row strobes since the last `fv_i` fall lies in [`vblank_i` − 5, `vblank_i` + 5). The lower bound is clamped at 0.
- R7: Two successive transitions of `sensor_stby_o` are at least EDGE_GAP (10) clock cycles apart. A frame-valid edge that comes sooner does not start standby.
- R8: Standby is released only while `stby_req_i` is low. Standby is low whenever reset is low.
- R9: If no `fv_i` rising edge occurs within STUCK_FRAMES × measured period clocks after release, `stuck_alarm_o` rises and `sensor_rst_no` falls in the same cycle, and the R1/R2 sequence is repeated. The alarm clears when `iface_rdy_o` rises again.
- R10: While `pwr_good_i` is low, all state resets at once: reset output low, standby, ready and alarm low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sensor clock |
| pwr_good_i | input | 1 | Supplies stable; low acts as asynchronous reset |
| fv_i | input | 1 | Frame-valid output of the sensor |
| row_stb_i | input | 1 | One-cycle pulse per row time |
| stby_req_i | input | 1 | Host standby request (level) |
| vblank_i | input | VB_W | Programmed vertical blanking, in row times |
| sensor_rst_no | output | 1 | Active-low hardware reset to the sensor |
| sensor_stby_o | output | 1 | Standby level to the sensor |
| iface_rdy_o | output | 1 | Serial interface may be used |
| stuck_alarm_o | output | 1 | Permanent-standby condition detected, recovery in progress |

## Verification
The bench targets the unsafe-window case. A vertical blanking value is chosen so that the frame-period hold ends inside the forbidden window. A design that ignored the window would release early; the bench sees this from the row count at release time. A request raised mid-blanking, and one raised mid-frame, must both wait for the next frame-valid edge. A pass-through design would assert standby at once. Right after a release, the sensor restarts a frame within a clock or two. A design without the edge spacing would re-enter standby on that rising edge instead of the later falling edge. In the stuck case, frames never resume. A design without the watchdog, or with the wrong limit, would either never raise the alarm or raise it at the wrong cycle, and would not repeat the reset length.

// File: rtl/snsr_seq_pkg.sv
package snsr_seq_pkg;

    typedef enum logic [1:0] {
        ST_RST  = 2'd0,
        ST_WAKE = 2'd1,
        ST_RUN  = 2'd2,
        ST_STBY = 2'd3
    } seq_st_e;

    // what the minimum standby hold is measured in
    typedef enum logic {
        HOLD_CLKS = 1'b0,
        HOLD_ROWS = 1'b1
    } hold_src_e;

endpackage

// File: rtl/snsr_frame_mon.sv
module snsr_frame_mon #(
    parameter int CNT_W      = 24,
    parameter int ROW_W      = 11,
    parameter int DFLT_FRAME = 1000
) (
    input  logic             clk_i,
    input  logic             arst_ni,
    input  logic             fv_i,
    input  logic             row_stb_i,
    input  logic             clr_seen_i,
    output logic             fv_rise_o,
    output logic             fv_fall_o,
    output logic [CNT_W-1:0] period_o,
    output logic [ROW_W-1:0] rows_o
);

    typedef struct packed {
        logic             fv;
        logic [CNT_W-1:0] per_cnt;
        logic [CNT_W-1:0] period;
        logic             seen;
        logic [ROW_W-1:0] rows;
    } mon_t;

    mon_t q, d;

    assign fv_rise_o = fv_i & ~q.fv;
    assign fv_fall_o = ~fv_i & q.fv;

    always_comb begin
        d    = q;
        d.fv = fv_i;
        if (q.per_cnt != '1) d.per_cnt = q.per_cnt + CNT_W'(1);
        if (fv_rise_o) begin
            if (q.seen) d.period = q.per_cnt + CNT_W'(1);
            d.seen    = 1'b1;
            d.per_cnt = '0;
        end
        // a gap caused by standby is not a frame period
        if (clr_seen_i) d.seen = 1'b0;
        if (fv_fall_o) d.rows = '0;
        else if (row_stb_i && q.rows != '1) d.rows = q.rows + ROW_W'(1);
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            q <= '{fv: 1'b0, per_cnt: '0, period: CNT_W'(DFLT_FRAME),
                   seen: 1'b0, rows: '1};
        end else begin
            q <= d;
        end
    end

    assign period_o = q.period;
    assign rows_o   = q.rows;

    // R6: the blanking row count only restarts or steps by one
    p_rows_step_r6: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (q.rows != $past(q.rows)) |-> (q.rows == '0 || q.rows == $past(q.rows) + ROW_W'(1)));

endmodule

// File: rtl/snsr_win_chk.sv
module snsr_win_chk #(
    parameter int VB_W  = 10,
    parameter int ROW_W = 11
) (
    input  logic [VB_W-1:0]  vblank_i,
    input  logic [ROW_W-1:0] rows_i,
    output logic             in_win_o
);

    logic [ROW_W-1:0] vb_ext, lo, hi;

    always_comb begin
        vb_ext   = ROW_W'(vblank_i);
        lo       = (vb_ext >= ROW_W'(5)) ? vb_ext - ROW_W'(5) : '0;
        hi       = vb_ext + ROW_W'(5);
        in_win_o = (rows_i >= lo) && (rows_i < hi);
    end

endmodule

// File: rtl/snsr_stby_ctrl.sv
module snsr_stby_ctrl
    import snsr_seq_pkg::*;
#(
    parameter int CLK_NS       = 8,
    parameter int RST_NS       = 750,
    parameter int IFACE_WAIT   = 10,
    parameter int EDGE_GAP     = 10,
    parameter int STUCK_FRAMES = 2,
    parameter int VB_W         = 10,
    parameter int CNT_W        = 24,
    parameter int DFLT_FRAME   = 1000
) (
    input  logic            clk_i,
    input  logic            pwr_good_i,
    input  logic            fv_i,
    input  logic            row_stb_i,
    input  logic            stby_req_i,
    input  logic [VB_W-1:0] vblank_i,
    output logic            sensor_rst_no,
    output logic            sensor_stby_o,
    output logic            iface_rdy_o,
    output logic            stuck_alarm_o
);

    localparam int RST_CYC = (RST_NS + CLK_NS - 1) / CLK_NS;
    localparam int ROW_W   = VB_W + 1;
    localparam int GAP_W   = $clog2(EDGE_GAP + 1);
    localparam int WC_W    = CNT_W + 4;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             rst_n;
        logic             rdy;
        logic             stby;
        logic             alarm;
        hold_src_e        src;
        logic             watch;
        logic [WC_W-1:0]  wcnt;
        logic [GAP_W-1:0] gap;
    } seq_t;

    seq_t q, d;

    logic             fv_rise, fv_fall, clr_seen, in_win;
    logic             gap_ok, hold_done;
    logic [CNT_W-1:0] period, rows_need;
    logic [ROW_W-1:0] rows;
    logic [WC_W-1:0]  stuck_lim;

    snsr_frame_mon #(.CNT_W(CNT_W), .ROW_W(ROW_W), .DFLT_FRAME(DFLT_FRAME)) u_mon (
        .clk_i      (clk_i),
        .arst_ni    (pwr_good_i),
        .fv_i       (fv_i),
        .row_stb_i  (row_stb_i),
        .clr_seen_i (clr_seen),
        .fv_rise_o  (fv_rise),
        .fv_fall_o  (fv_fall),
        .period_o   (period),
        .rows_o     (rows)
    );

    snsr_win_chk #(.VB_W(VB_W), .ROW_W(ROW_W)) u_win (
        .vblank_i (vblank_i),
        .rows_i   (rows),
        .in_win_o (in_win)
    );

    assign rows_need = CNT_W'(vblank_i) + CNT_W'(5);
    assign stuck_lim = WC_W'(period) * WC_W'(STUCK_FRAMES);
    assign gap_ok    = (q.gap >= GAP_W'(EDGE_GAP));
    assign hold_done = (q.src == HOLD_ROWS) ? (q.cnt >= rows_need) : (q.cnt >= period);

    always_comb begin
        d        = q;
        clr_seen = 1'b0;
        if (q.gap < GAP_W'(EDGE_GAP)) d.gap = q.gap + GAP_W'(1);
        case (q.st)
            ST_RST: begin
                if (q.cnt == CNT_W'(RST_CYC - 1)) begin
                    d.st    = ST_WAKE;
                    d.cnt   = '0;
                    d.rst_n = 1'b1;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_WAKE: begin
                if (q.cnt == CNT_W'(IFACE_WAIT - 1)) begin
                    d.st    = ST_RUN;
                    d.cnt   = '0;
                    d.rdy   = 1'b1;
                    d.alarm = 1'b0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_RUN: begin
                if (q.watch) begin
                    if (fv_rise) d.watch = 1'b0;
                    else         d.wcnt  = q.wcnt + WC_W'(1);
                end
                if (q.watch && !fv_rise && q.wcnt >= stuck_lim) begin
                    d.st    = ST_RST;
                    d.cnt   = '0;
                    d.rst_n = 1'b0;
                    d.rdy   = 1'b0;
                    d.alarm = 1'b1;
                    d.watch = 1'b0;
                end else if (stby_req_i && gap_ok && (fv_rise || fv_fall)) begin
                    d.st     = ST_STBY;
                    d.stby   = 1'b1;
                    d.gap    = '0;
                    d.cnt    = '0;
                    d.src    = fv_fall ? HOLD_ROWS : HOLD_CLKS;
                    d.watch  = 1'b0;
                    clr_seen = 1'b1;
                end
            end
            ST_STBY: begin
                if ((q.src == HOLD_CLKS || row_stb_i) && q.cnt != '1) d.cnt = q.cnt + CNT_W'(1);
                if (!stby_req_i && hold_done && gap_ok && !in_win) begin
                    d.st    = ST_RUN;
                    d.stby  = 1'b0;
                    d.gap   = '0;
                    d.watch = 1'b1;
                    d.wcnt  = '0;
                end
            end
            default: d.st = ST_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            q <= '{st: ST_RST, cnt: '0, rst_n: 1'b0, rdy: 1'b0, stby: 1'b0,
                   alarm: 1'b0, src: HOLD_CLKS, watch: 1'b0, wcnt: '0,
                   gap: GAP_W'(EDGE_GAP)};
        end else begin
            q <= d;
        end
    end

    assign sensor_rst_no = q.rst_n;
    assign sensor_stby_o = q.stby;
    assign iface_rdy_o   = q.rdy;
    assign stuck_alarm_o = q.alarm;

    // observation counters for the timing properties
    logic [CNT_W-1:0] low_run, hi_run, gap_run;
    logic             stby_prv;

    always_ff @(posedge clk_i or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            low_run  <= '0;
            hi_run   <= '0;
            gap_run  <= CNT_W'(EDGE_GAP);
            stby_prv <= 1'b0;
        end else begin
            low_run  <= q.rst_n ? '0 : ((low_run == '1) ? low_run : low_run + CNT_W'(1));
            hi_run   <= !q.rst_n ? '0 : ((hi_run == '1) ? hi_run : hi_run + CNT_W'(1));
            stby_prv <= q.stby;
            gap_run  <= (q.stby != stby_prv) ? '0 :
                        ((gap_run == '1) ? gap_run : gap_run + CNT_W'(1));
        end
    end

    p_rst_width_r1: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        $rose(sensor_rst_no) |-> (low_run >= CNT_W'(RST_CYC)));

    p_rdy_delay_r2: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        $rose(iface_rdy_o) |-> (hi_run >= CNT_W'(IFACE_WAIT)));

    p_rdy_needs_rst_r2: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !sensor_rst_no |-> !iface_rdy_o);

    p_entry_on_edge_r3: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        $rose(sensor_stby_o) |-> $past(fv_rise || fv_fall));

    p_stby_gap_r7: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        ($rose(sensor_stby_o) || $fell(sensor_stby_o)) |-> (gap_run >= CNT_W'(EDGE_GAP)));

    p_no_stby_in_rst_r8: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !sensor_rst_no |-> !sensor_stby_o);

    p_alarm_resets_r9: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        $rose(stuck_alarm_o) |-> !sensor_rst_no);

endmodule

// File: tb/snsr_stby_ctrl_tb_top.sv
module snsr_stby_ctrl_tb_top;

    localparam int FH = 60;
    localparam int FL = 40;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic       fv = 1'b0;
    logic       row_stb = 1'b0;
    logic       req = 1'b0;
    logic [9:0] vb = 10'd20;
    logic       rst_n, stby, rdy, alarm;

    int  total = 0;
    int  bad = 0;
    bit  frames_on = 1'b0;
    int  rc = 0;
    int  rows_b = 4095;
    bit  fv_prev_b = 1'b0;

    always #4 clk = ~clk;

    snsr_stby_ctrl dut_i (
        .clk_i         (clk),
        .pwr_good_i    (pwr_good),
        .fv_i          (fv),
        .row_stb_i     (row_stb),
        .stby_req_i    (req),
        .vblank_i      (vb),
        .sensor_rst_no (rst_n),
        .sensor_stby_o (stby),
        .iface_rdy_o   (rdy),
        .stuck_alarm_o (alarm)
    );

    // row-time strobe, one pulse every 4 clocks
    always begin
        @(posedge clk);
        #1;
        rc      = rc + 1;
        row_stb = (rc % 4 == 0);
    end

    // sensor model: finishes any frame it started, idles while in standby
    always begin
        @(posedge clk);
        #1;
        if (frames_on && !stby) begin
            fv = 1'b1;
            repeat (FH) @(posedge clk);
            #1;
            fv = 1'b0;
            repeat (FL - 1) @(posedge clk);
        end
    end

    // rows since the last frame-valid fall, from the inputs alone
    always @(posedge clk) begin
        if (fv_prev_b && !fv) rows_b = 0;
        else if (row_stb && rows_b < 4095) rows_b = rows_b + 1;
        fv_prev_b = fv;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wait_fv(input bit val);
        do @(negedge clk); while (fv != val);
    endtask

    task automatic wait_stby(input bit val, output int n);
        n = 0;
        while (stby != val) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_power_up;
        int n;
        @(negedge clk);
        chk(rst_n == 1'b0, "R10", rst_n, 0);
        chk(stby == 1'b0, "R10", stby, 0);
        chk(rdy == 1'b0, "R10", rdy, 0);
        chk(alarm == 1'b0, "R10", alarm, 0);
        pwr_good = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!rst_n && n < 1000);
        chk(n == 94, "R1", n, 94);
        n = 0;
        do begin @(negedge clk); n++; end while (!rdy && n < 1000);
        chk(n == 10, "R2", n, 10);
    endtask

    // request in blanking, entry on rising edge, hold one frame period
    task automatic t_rise_entry(input int vbv, input bit expect_window);
        int n, prev_rows, cur_rows, lo;
        vb = 10'(vbv);
        wait_fv(1);
        wait_fv(0);
        repeat (10) @(negedge clk);
        req = 1'b1;
        while (fv == 1'b0) begin
            chk(stby == 1'b0, "R3 pending", stby, 0);
            @(negedge clk);
        end
        chk(stby == 1'b0, "R3 edge seen", stby, 0);
        @(negedge clk);
        chk(stby == 1'b1, "R3 entry", stby, 1);
        req = 1'b0;
        n = 1;
        cur_rows = rows_b;
        prev_rows = cur_rows;
        while (stby && n < 5000) begin
            @(negedge clk);
            prev_rows = cur_rows;
            cur_rows = rows_b;
            n++;
        end
        n--;
        chk(n >= 100, "R4 hold", n, 100);
        lo = (vbv >= 5) ? vbv - 5 : 0;
        chk(prev_rows < lo || prev_rows >= vbv + 5, "R6 window", prev_rows, vbv + 5);
        if (expect_window) chk(n > 110, "R6 extended", n, 111);
        else               chk(n <= 102, "R4 release", n, 101);
    endtask

    // request mid-frame, entry on falling edge, hold in rows, then spacing
    task automatic t_fall_entry;
        int n, strobes, low_n;
        vb = 10'd20;
        repeat (2) wait_fv(0);
        wait_fv(1);
        repeat (10) @(negedge clk);
        req = 1'b1;
        while (fv == 1'b1) begin
            chk(stby == 1'b0, "R3 pending", stby, 0);
            @(negedge clk);
        end
        chk(stby == 1'b0, "R3 edge seen", stby, 0);
        @(negedge clk);
        chk(stby == 1'b1, "R3 entry", stby, 1);
        req = 1'b0;
        strobes = 0;
        n = 0;
        while (stby && n < 5000) begin
            if (row_stb) strobes++;
            @(negedge clk);
            n++;
        end
        chk(strobes >= 25 && strobes <= 26, "R5 rows", strobes, 25);
        // sensor restarts a frame at once; that rise must not start standby
        req = 1'b1;
        low_n = 0;
        while (!stby && low_n < 5000) begin
            @(negedge clk);
            low_n++;
        end
        chk(low_n >= 10, "R7 gap", low_n, 10);
        chk(low_n >= 50, "R7 skip early rise", low_n, 61);
        chk(fv == 1'b0, "R7 entry on fall", fv, 0);
        // request still high past the hold: stays in standby
        repeat (150) @(negedge clk);
        chk(stby == 1'b1, "R8 held", stby, 1);
        req = 1'b0;
        wait_stby(1'b0, n);
        chk(n <= 3, "R8 release", n, 1);
    endtask

    task automatic t_stuck;
        int n;
        repeat (2) wait_fv(0);
        wait_fv(1);
        req = 1'b1;
        wait_stby(1'b1, n);
        req = 1'b0;
        frames_on = 1'b0;
        wait_stby(1'b0, n);
        n = 0;
        while (!alarm && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n >= 199 && n <= 203, "R9 alarm time", n, 201);
        chk(rst_n == 1'b0, "R9 reset", rst_n, 0);
        n = 0;
        while (!rst_n && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n == 94, "R9 R1 reset width", n, 94);
        chk(alarm == 1'b1, "R9 alarm held", alarm, 1);
        frames_on = 1'b1;
        n = 0;
        while (!rdy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n == 10, "R9 R2 ready", n, 10);
        chk(alarm == 1'b0, "R9 alarm clear", alarm, 0);
    endtask

    task automatic t_power_loss;
        repeat (150) @(negedge clk);
        pwr_good = 1'b0;
        #1;
        chk(rst_n == 1'b0, "R10", rst_n, 0);
        chk(stby == 1'b0, "R10", stby, 0);
        chk(rdy == 1'b0, "R10", rdy, 0);
        chk(alarm == 1'b0, "R10", alarm, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_power_up();
        frames_on = 1'b1;
        repeat (300) @(negedge clk);
        t_rise_entry(20, 1'b0);
        repeat (250) @(negedge clk);
        t_rise_entry(12, 1'b1);
        repeat (250) @(negedge clk);
        t_fall_entry();
        t_stuck();
        t_power_loss();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule